// File: doc/BRIEF.md
# Register-Based LIFO Stack with Full and Empty Flags

This block is a last-in-first-out store of 64 words held in flip-flops. A six-bit pointer marks the top of the stack. Two status flags report whether the stack holds no items or all 64. Upstream control logic raises `push_i` to store the word on `wr_data_i`, or `pop_i` to take the top word back. The popped word is returned on a registered data output. The current top word is also available combinationally at all times.

The pointer is advanced before a push writes, so the first item lands at address 1. The pointer wraps modulo 64, so the 64th item lands at address 0. The flags follow from the pointer returning to zero, not from a separate item count. Some requests are illegal: a push while full, a pop while empty, or both strobes in the same cycle. Such a request is refused, leaves all state untouched, and produces a one-cycle error pulse.

Reset is asynchronous and active-low. Its release is synchronised inside the block, so operation starts two clock edges after `rst_n` rises.

Top module: `lifo_regstack`

## Requirements
- R1: After reset the pointer reads 0, the empty flag is 1, the full flag is 0, the error output is 0 and the popped-data output is 0.
- R2: An accepted push (push_i=1, pop_i=0, not full) increments the pointer and then writes wr_data_i into the word at the new pointer. The first item after reset is therefore stored at address 1.
- R3: Any accepted push clears the empty flag. When the incremented pointer wraps to 0, the full flag is set and the 64th item resides at address 0. The two flags are never both 1.
- R4: An accepted pop (pop_i=1, push_i=0, not empty) places the word at the current pointer on rd_data_o after the same clock edge, then decrements the pointer and clears the full flag.
- R5: When an accepted pop brings the pointer to 0, the empty flag is set.
- R6: A push while full changes no state: pointer, flags and stored words stay the same. It raises err_o after the edge.
- R7: A pop while empty changes no state, leaves rd_data_o unchanged, and raises err_o after the edge.
- R8: push_i and pop_i asserted together is an error that changes no state and raises err_o.
- R9: err_o is high for exactly the one cycle following an illegal request, and is 0 after every legal or idle cycle.
- R10: tos_o shows, without a clock delay, the word at the current pointer. When not empty, this is the most recently pushed item not yet popped.
- R11: A cycle with neither strobe leaves the pointer, flags, rd_data_o and tos_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push request strobe |
| pop_i | input | 1 | Pop request strobe |
| wr_data_i | input | DATA_W | Word to push |
| rd_data_o | output | DATA_W | Registered word from the last accepted pop |
| tos_o | output | DATA_W | Combinational word at the pointer |
| sp_o | output | ADDR_W | Stack pointer |
| full_o | output | 1 | Stack holds 2**ADDR_W items |
| empty_o | output | 1 | Stack holds no items |
| err_o | output | 1 | One-cycle pulse after an illegal request |

## Verification
Every result of a request is due one clock edge after the edge that samples it: the pointer, both flags, err_o, rd_data_o, and tos_o, which follows the new pointer. The bench drives strobes on the falling edge. It advances a queue-based model at the next rising edge and compares all outputs 1 ns after that edge, so each comparison lands in the cycle where the result first appears. Two cycles are allowed after reset release for the internal synchroniser before the R1 values are checked. The illegal-request checks compare the following pops against the model's queue, which confirms at the ports that refused requests wrote nothing.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } stk_op_e;

endpackage

// File: rtl/lifo_rst_sync.sv
module lifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_q [DEPTH];

  // one enabled register per word; contents are not reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic sel;
    assign sel = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (sel) begin
        word_q[g] <= wdata;
      end
    end
  end

  assign rdata = word_q[raddr];

endmodule

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              rd_en_o
);

  localparam logic [ADDR_W-1:0] SP_ZERO = '0;
  localparam logic [ADDR_W-1:0] SP_ONE  = ADDR_W'(1);

  stk_op_e           op;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              full_q, full_d;
  logic              empty_q, empty_d;
  logic              err_q, err_d;
  logic [ADDR_W-1:0] sp_inc, sp_dec;

  assign sp_inc = sp_q + SP_ONE;
  assign sp_dec = sp_q - SP_ONE;

  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op = full_q  ? OP_BAD : OP_PUSH;
      2'b01:   op = empty_q ? OP_BAD : OP_POP;
      2'b11:   op = OP_BAD;
      default: op = OP_IDLE;
    endcase
  end

  always_comb begin
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    err_d   = 1'b0;
    unique case (op)
      OP_PUSH: begin
        sp_d    = sp_inc;
        full_d  = (sp_inc == SP_ZERO);
        empty_d = 1'b0;
      end
      OP_POP: begin
        sp_d    = sp_dec;
        empty_d = (sp_dec == SP_ZERO);
        full_d  = 1'b0;
      end
      OP_BAD:  err_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= SP_ZERO;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      sp_q    <= sp_d;
      full_q  <= full_d;
      empty_q <= empty_d;
      err_q   <= err_d;
    end
  end

  assign sp_o      = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;
  assign wr_en_o   = (op == OP_PUSH);
  assign wr_addr_o = sp_inc;
  assign rd_en_o   = (op == OP_POP);

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (sp_o == ADDR_W'($past(sp_o) + 1)) && !empty_o);

  p_fill_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o && (sp_o == '1)) |=> full_o && (sp_o == '0));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (sp_o == ADDR_W'($past(sp_o) - 1)) && !full_o);

  p_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o && (sp_o == ADDR_W'(1))) |=> empty_o);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> $stable(sp_o) && full_o && err_o);

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && empty_o) |=> $stable(sp_o) && empty_o && err_o);

  p_both_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o) && err_o);

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(push_i && pop_i) && !(push_i && full_o) && !(pop_i && empty_o)) |=> !err_o);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o));

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] tos_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);

  logic              rst_sync_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              rd_en;
  logic [DATA_W-1:0] top_word;
  logic [DATA_W-1:0] rd_q;

  lifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .sp_o      (sp_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en)
  );

  lifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data_i),
    .raddr (sp_o),
    .rdata (top_word)
  );

  // data register: captures the word at the pointer before it moves down
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= top_word;
    end
  end

  assign rd_data_o = rd_q;
  assign tos_o     = top_word;

  p_pop_data_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop_i && !push_i && !empty_o) |=> (rd_data_o == $past(tos_o)));

  p_push_visible_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (push_i && !pop_i && !full_o) |=> (tos_o == $past(wr_data_i)));

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pop_i && empty_o) |=> $stable(rd_data_o));

endmodule

// File: tb/lifo_regstack_bench.sv
module lifo_regstack_bench;

  localparam int DW    = 8;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push, pop;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rd_data, tos;
  logic [AW-1:0] sp;
  logic          full, empty, err;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] model_q[$];
  logic [DW-1:0] exp_rd;
  bit            exp_err;

  always #2 clk = ~clk;

  lifo_regstack #(.DATA_W(DW), .ADDR_W(AW)) u_lifo_regstack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push),
    .pop_i     (pop),
    .wr_data_i (wdata),
    .rd_data_o (rd_data),
    .tos_o     (tos),
    .sp_o      (sp),
    .full_o    (full),
    .empty_o   (empty),
    .err_o     (err)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int n;
    n = model_q.size();
    chk(tag, "sp", int'(sp), n % DEPTH);
    chk(tag, "full", int'(full), (n == DEPTH) ? 1 : 0);
    chk(tag, "empty", int'(empty), (n == 0) ? 1 : 0);
    chk(tag, "err", int'(err), exp_err ? 1 : 0);
    chk(tag, "rd_data", int'(rd_data), int'(exp_rd));
    if (n != 0) chk(tag, "tos", int'(tos), int'(model_q[n-1]));
  endtask

  task automatic step(bit p_push, bit p_pop, logic [DW-1:0] d, string tag);
    int n;
    @(negedge clk);
    push = p_push; pop = p_pop; wdata = d;
    @(posedge clk);
    n = model_q.size();
    exp_err = 1'b0;
    if (p_push && p_pop) exp_err = 1'b1;
    else if (p_push) begin
      if (n == DEPTH) exp_err = 1'b1; else model_q.push_back(d);
    end else if (p_pop) begin
      if (n == 0) exp_err = 1'b1; else exp_rd = model_q.pop_back();
    end
    #1;
    compare(tag);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none

    rst_n = 1'b0; push = 1'b0; pop = 1'b0; wdata = '0;
    exp_rd = '0; exp_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");

    // R2/R10: first pushes, first item at address 1
    step(1, 0, 8'hA1, "R2");
    chk("R2", "first item address", int'(sp), 1);
    step(1, 0, 8'hB2, "R2");
    step(1, 0, 8'hC3, "R10");
    // R4: pop returns top word
    step(0, 1, 8'h00, "R4");
    chk("R4", "popped word", int'(rd_data), 8'hC3);
    // R11: idle
    for (int i = 0; i < 3; i++) step(0, 0, 8'h55, "R11");
    // R5: drain to empty
    step(0, 1, 8'h00, "R4");
    step(0, 1, 8'h00, "R5");
    chk("R5", "empty after drain", int'(empty), 1);
    // R7: pop while empty
    step(0, 1, 8'h00, "R7");
    chk("R7", "rd_data held", int'(rd_data), 8'hA1);
    step(0, 0, 8'h00, "R9");
    // R8: both strobes
    step(1, 1, 8'h77, "R8");
    step(1, 0, 8'h10, "R8");
    step(1, 1, 8'h78, "R8");
    step(0, 0, 8'h00, "R9");
    step(0, 1, 8'h00, "R8");
    // R3: fill all words
    for (int i = 0; i < DEPTH; i++) step(1, 0, DW'(8'h40 + i), "R3");
    chk("R3", "full after fill", int'(full), 1);
    chk("R3", "64th item at address 0", int'(sp), 0);
    // R6: push while full
    step(1, 0, 8'hEE, "R6");
    step(1, 0, 8'hEF, "R6");
    step(0, 0, 8'h00, "R9");
    // pop everything, contents verify nothing was overwritten
    for (int i = 0; i < DEPTH; i++) step(0, 1, 8'h00, "R6");
    chk("R5", "empty after full drain", int'(empty), 1);
    // mixed traffic
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      step(r < 5 || r == 9, r >= 5 && r != 8 || r == 9 ? r >= 5 : 1'b0,
           DW'($urandom), "R9");
    end
    // fill again through wrap and verify via pops
    while (model_q.size() < DEPTH) step(1, 0, DW'($urandom), "R3");
    step(1, 0, 8'h01, "R6");
    step(0, 1, 8'h00, "R4");
    step(1, 0, 8'h99, "R2");
    chk("R3", "refill to full", int'(full), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule